// File: doc/BRIEF.md
# Pipeline Interlock Hazard Detector

This block detects read-after-write hazards for a five-stage in-order pipeline that has no forwarding paths. It holds the instruction currently in decode, works out from its opcode which register fields it really reads and which register it will write, and compares the read fields against the pending destinations of the instructions in execute, memory and writeback. When any live match exists it raises a stall: the decode register keeps its instruction, the fetch side is told to hold, and an empty slot is sent into execute in place of the waiting instruction.

A short tag pipeline carries the valid bit, write enable and destination of each instruction from execute to writeback. This lets the detector be driven one instruction per cycle and observed over time. The instruction format uses a 6-bit opcode and three 5-bit register fields. Per-operand read enables keep immediate, store, branch and jump forms from stalling on fields they never read. The destination is chosen per opcode class from the third field, the second field, or the fixed link register.

Top module: `hazard_interlock`

## Requirements
- R1: Opcode values are ALU=0x00, ALUI=0x08, LW=0x23, SW=0x2B, BEQZ=0x04, BNEZ=0x05, J=0x02, JAL=0x03, JR=0x10, JALR=0x11. Any other value reads nothing and writes nothing. Register fields are 5 bits wide.
- R2: A stall is raised while the decode instruction reads its first source (field `f_rs`) and that register equals the write-enabled destination of the execute, memory or writeback slot.
- R3: The same comparison applies to the second source (field `f_rt`), but only when the opcode reads a second source.
- R4: The first source is read by ALU, ALUI, LW, SW, BEQZ, BNEZ, JR and JALR, and not by J or JAL. The second source is read only by ALU and SW.
- R5: ALU writes `f_rd`; ALUI and LW write `f_rt`; JAL and JALR write register 31; SW, BEQZ, BNEZ and J write nothing.
- R6: Register 0 is never a valid destination. An instruction naming it carries write enable 0, and a match on register 0 never stalls.
- R7: While stalled, the decode register keeps its instruction and the fetch inputs are ignored. The held instruction is the one that later enters execute.
- R8: Each stalled cycle places an empty slot (valid 0, write enable 0) in execute. Empty slots never cause later matches.
- R9: A consumer separated from its producer by k independent instructions (k = 0..3) is stalled for exactly 3-k cycles.
- R10: With no hazard there is no stall. Each instruction's valid, write enable and destination move from execute to memory to writeback one stage per cycle.
- R11: After a synchronous active-high reset, stall is low and all three slots are empty with write enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid | input | 1 | Fetch slot holds an instruction |
| f_op | input | 6 | Fetched opcode |
| f_rs | input | 5 | Fetched first register field |
| f_rt | input | 5 | Fetched second register field |
| f_rd | input | 5 | Fetched third register field |
| stall | output | 1 | Hold fetch and decode; empty slot into execute |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_we | output | 1 | Execute slot writes a register |
| ex_dst | output | 5 | Execute slot destination |
| mem_we | output | 1 | Memory slot writes a register |
| mem_dst | output | 5 | Memory slot destination |
| wb_we | output | 1 | Writeback slot writes a register |
| wb_dst | output | 5 | Writeback slot destination |

## Verification
Two events can land in the same cycle: a first-source match against one stage and a second-source match against a different stage. The bench builds this with two producers in a row that write different registers, followed by a consumer that reads both. The nearer producer alone should set the stall length, so the stall count is compared with the count for a single producer at that distance. A second overlap is a stall cycle in which the fetch inputs change. Here the bench checks that the instruction leaving decode afterwards is the held one and not the one presented during the stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int N_WATCH = 3;
    localparam logic [REG_W-1:0] LINK_REG = REG_W'((1 << REG_W) - 1);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    typedef logic [REG_W-1:0] reg_id_t;

    typedef enum logic [OP_W-1:0] {
        OP_ALU  = 6'h00,
        OP_J    = 6'h02,
        OP_JAL  = 6'h03,
        OP_BEQZ = 6'h04,
        OP_BNEZ = 6'h05,
        OP_ALUI = 6'h08,
        OP_JR   = 6'h10,
        OP_JALR = 6'h11,
        OP_LW   = 6'h23,
        OP_SW   = 6'h2B
    } opcode_e;

    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   op;
        reg_id_t           rs;
        reg_id_t           rt;
        reg_id_t           rd;
    } instr_t;

    typedef struct packed {
        logic    rd_a;
        logic    rd_b;
        logic    we;
        reg_id_t dst;
    } usage_t;

    typedef struct packed {
        logic    valid;
        logic    we;
        reg_id_t dst;
    } slot_tag_t;

    localparam slot_tag_t EMPTY_SLOT = '{valid: 1'b0, we: 1'b0, dst: '0};

    function automatic usage_t classify(input instr_t ins);
        usage_t  u;
        logic    writes;
        u      = '0;
        writes = 1'b0;
        case (ins.op)
            OP_ALU:  begin u.rd_a = 1'b1; u.rd_b = 1'b1; writes = 1'b1; u.dst = ins.rd;   end
            OP_ALUI,
            OP_LW:   begin u.rd_a = 1'b1; writes = 1'b1; u.dst = ins.rt;                  end
            OP_SW:   begin u.rd_a = 1'b1; u.rd_b = 1'b1;                                  end
            OP_BEQZ,
            OP_BNEZ,
            OP_JR:   begin u.rd_a = 1'b1;                                                 end
            OP_JAL:  begin writes = 1'b1; u.dst = LINK_REG;                               end
            OP_JALR: begin u.rd_a = 1'b1; writes = 1'b1; u.dst = LINK_REG;                end
            default: begin                                                                end
        endcase
        u.rd_a = u.rd_a & ins.valid;
        u.rd_b = u.rd_b & ins.valid;
        u.we   = writes & ins.valid & (u.dst != ZERO_REG);
        if (!u.we) u.dst = ZERO_REG;
        return u;
    endfunction

endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
    import hzd_pkg::*;
(
    input  instr_t ins,
    output usage_t use_o
);
    always_comb begin
        use_o = classify(ins);
    end

    always_comb begin
        if (use_o.rd_b) assert_second_implies_first_R4: assert (use_o.rd_a);
        if (ins.valid && (ins.op == OP_J || ins.op == OP_JAL))
            assert_jumps_skip_first_R4: assert (!use_o.rd_a && !use_o.rd_b);
        if (use_o.we) assert_dest_nonzero_R6: assert (use_o.dst != ZERO_REG);
    end
endmodule

// File: rtl/hzd_match.sv
module hzd_match
    import hzd_pkg::*;
#(
    parameter int NUM_SLOTS = N_WATCH
)(
    input  reg_id_t                       src_a,
    input  reg_id_t                       src_b,
    input  logic                          rd_a,
    input  logic                          rd_b,
    input  slot_tag_t [NUM_SLOTS-1:0]     slots,
    output logic      [NUM_SLOTS-1:0]     hit,
    output logic                          stall
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic live;
        assign live   = slots[s].valid & slots[s].we & (slots[s].dst != ZERO_REG);
        assign hit[s] = live & ((rd_a & (src_a == slots[s].dst)) |
                                (rd_b & (src_b == slots[s].dst)));
    end

    assign stall = |hit;

    always_comb begin
        if (!rd_a && !rd_b) assert_no_reads_no_stall_R4: assert (!stall);
    end
endmodule

// File: rtl/hzd_tag_pipe.sv
module hzd_tag_pipe
    import hzd_pkg::*;
#(
    parameter int DEPTH = N_WATCH
)(
    input  logic                      clk,
    input  logic                      rst,
    input  slot_tag_t                 tag_in,
    output slot_tag_t [DEPTH-1:0]     taps
);
    for (genvar d = 0; d < DEPTH; d++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)     taps[d] <= EMPTY_SLOT;
            else if (d == 0) taps[d] <= tag_in;
            else         taps[d] <= taps[(d == 0) ? 0 : d-1];
        end
        if (d > 0) begin : g_chk
            assert_tag_advances_R10: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> taps[d] == $past(taps[d-1]));
        end
    end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              f_valid,
    input  logic [OP_W-1:0]   f_op,
    input  logic [REG_W-1:0]  f_rs,
    input  logic [REG_W-1:0]  f_rt,
    input  logic [REG_W-1:0]  f_rd,
    output logic              stall,
    output logic              ex_valid,
    output logic              ex_we,
    output logic [REG_W-1:0]  ex_dst,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_dst,
    output logic              wb_we,
    output logic [REG_W-1:0]  wb_dst
);
    localparam int EX_I  = 0;
    localparam int MEM_I = 1;
    localparam int WB_I  = 2;

    instr_t                      id_q;
    usage_t                      id_use;
    slot_tag_t                   ex_in;
    slot_tag_t [N_WATCH-1:0]     slots;
    logic      [N_WATCH-1:0]     hit;

    always_ff @(posedge clk) begin
        if (rst)         id_q <= '0;
        else if (!stall) id_q <= '{valid: f_valid, op: f_op, rs: f_rs, rt: f_rt, rd: f_rd};
    end

    hzd_decode u_decode (
        .ins   (id_q),
        .use_o (id_use)
    );

    hzd_match #(.NUM_SLOTS(N_WATCH)) u_match (
        .src_a (id_q.rs),
        .src_b (id_q.rt),
        .rd_a  (id_use.rd_a),
        .rd_b  (id_use.rd_b),
        .slots (slots),
        .hit   (hit),
        .stall (stall)
    );

    always_comb begin
        if (stall) ex_in = EMPTY_SLOT;
        else       ex_in = '{valid: id_q.valid, we: id_use.we, dst: id_use.dst};
    end

    hzd_tag_pipe #(.DEPTH(N_WATCH)) u_tags (
        .clk    (clk),
        .rst    (rst),
        .tag_in (ex_in),
        .taps   (slots)
    );

    assign ex_valid = slots[EX_I].valid;
    assign ex_we    = slots[EX_I].we;
    assign ex_dst   = slots[EX_I].dst;
    assign mem_we   = slots[MEM_I].we;
    assign mem_dst  = slots[MEM_I].dst;
    assign wb_we    = slots[WB_I].we;
    assign wb_dst   = slots[WB_I].dst;

    assert_decode_held_R7: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(id_q));

    assert_bubble_inserted_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!ex_valid && !ex_we));

    assert_stall_has_live_dest_R6: assert property (@(posedge clk) disable iff (rst)
        stall |-> ((ex_we && ex_dst != '0) || (mem_we && mem_dst != '0) ||
                   (wb_we && wb_dst != '0)));

    assert_issue_when_free_R10: assert property (@(posedge clk) disable iff (rst)
        (!stall && id_q.valid) |=> ex_valid);

    assert_empty_after_reset_R11: assert property (@(posedge clk)
        rst |=> (!ex_valid && !ex_we && !mem_we && !wb_we));
endmodule

// File: tb/hazard_interlock_tb.sv
module hazard_interlock_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] C_ALU  = 6'h00, C_J    = 6'h02, C_JAL  = 6'h03,
                           C_BEQZ = 6'h04, C_ALUI = 6'h08, C_JR   = 6'h10,
                           C_JALR = 6'h11, C_LW   = 6'h23, C_SW   = 6'h2B,
                           C_BAD  = 6'h3F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       f_valid = 1'b0;
    logic [5:0] f_op = '0;
    logic [4:0] f_rs = '0, f_rt = '0, f_rd = '0;
    logic       stall, ex_valid, ex_we, mem_we, wb_we;
    logic [4:0] ex_dst, mem_dst, wb_dst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_interlock u_dut (
        .clk(clk), .rst(rst), .f_valid(f_valid), .f_op(f_op), .f_rs(f_rs),
        .f_rt(f_rt), .f_rd(f_rd), .stall(stall), .ex_valid(ex_valid),
        .ex_we(ex_we), .ex_dst(ex_dst), .mem_we(mem_we), .mem_dst(mem_dst),
        .wb_we(wb_we), .wb_dst(wb_dst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one instruction; return the number of stall cycles it saw in decode.
    task automatic issue(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                         input logic [4:0] rd, input bit scramble, output int n);
        while (stall) @(negedge clk);
        f_valid = 1'b1; f_op = op; f_rs = rs; f_rt = rt; f_rd = rd;
        @(negedge clk);
        n = 0;
        while (stall) begin
            if (scramble) begin
                f_op = C_ALU; f_rs = 5'd1; f_rt = 5'd1; f_rd = 5'd20;
            end
            n++;
            @(negedge clk);
            chk("R8 empty slot after stall cycle", {ex_valid, ex_we}, 0);
            if (n > 10) break;
        end
    endtask

    task automatic filler();
        int n;
        issue(C_J, 5'd0, 5'd0, 5'd0, 1'b0, n);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) filler();
    endtask

    task automatic t_reset();
        chk("R11 stall", stall, 0);
        chk("R11 ex_valid", ex_valid, 0);
        chk("R11 write enables", {ex_we, mem_we, wb_we}, 0);
    endtask

    task automatic t_distance(input int k);
        int n;
        drain();
        issue(C_ALUI, 5'd1, 5'd5, 5'd0, 1'b0, n);
        for (int i = 0; i < k; i++) filler();
        issue(C_ALU, 5'd5, 5'd2, 5'd6, 1'b0, n);
        chk($sformatf("R9 R2 stall cycles at distance %0d", k), n, 3 - k);
    endtask

    task automatic t_second_src();
        int n;
        drain();
        issue(C_LW, 5'd3, 5'd9, 5'd0, 1'b0, n);
        issue(C_SW, 5'd4, 5'd9, 5'd0, 1'b0, n);
        chk("R3 store second source stalls", n, 3);
        drain();
        issue(C_LW, 5'd3, 5'd9, 5'd0, 1'b0, n);
        issue(C_ALUI, 5'd4, 5'd9, 5'd0, 1'b0, n);
        chk("R3 R4 ALUI field rt not read", n, 0);
    endtask

    task automatic t_read_enables();
        int n;
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b0, n);
        issue(C_J, 5'd7, 5'd7, 5'd0, 1'b0, n);
        chk("R4 J reads nothing", n, 0);
        issue(C_JAL, 5'd7, 5'd7, 5'd0, 1'b0, n);
        chk("R4 JAL reads nothing", n, 0);
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b0, n);
        issue(C_BEQZ, 5'd7, 5'd0, 5'd0, 1'b0, n);
        chk("R4 branch reads first source", n, 3);
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b0, n);
        issue(C_JR, 5'd8, 5'd7, 5'd0, 1'b0, n);
        chk("R4 JR ignores second field", n, 0);
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b0, n);
        issue(C_BAD, 5'd7, 5'd7, 5'd7, 1'b0, n);
        chk("R1 unknown opcode reads nothing", n, 0);
    endtask

    task automatic dest_of(input logic [5:0] op, input int exp_we, input int exp_dst,
                           input string tag);
        int n;
        drain();
        issue(op, 5'd11, 5'd12, 5'd13, 1'b0, n);
        filler();
        chk({"R5 we ", tag}, ex_we, exp_we);
        if (exp_we != 0) chk({"R5 dst ", tag}, ex_dst, exp_dst);
    endtask

    task automatic t_destinations();
        dest_of(C_ALU,  1, 13, "ALU");
        dest_of(C_ALUI, 1, 12, "ALUI");
        dest_of(C_LW,   1, 12, "LW");
        dest_of(C_JAL,  1, 31, "JAL");
        dest_of(C_JALR, 1, 31, "JALR");
        dest_of(C_SW,   0, 0,  "SW");
        dest_of(C_BEQZ, 0, 0,  "BEQZ");
        dest_of(C_J,    0, 0,  "J");
    endtask

    task automatic t_link_hazard();
        int n;
        drain();
        issue(C_JAL, 5'd0, 5'd0, 5'd0, 1'b0, n);
        filler();
        issue(C_ALU, 5'd31, 5'd2, 5'd4, 1'b0, n);
        chk("R5 R2 link register dependence", n, 2);
    endtask

    task automatic t_zero_reg();
        int n;
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd0, 1'b0, n);
        filler();
        chk("R6 dest 0 write enable", ex_we, 0);
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd0, 1'b0, n);
        issue(C_ALU, 5'd0, 5'd0, 5'd3, 1'b0, n);
        chk("R6 register 0 never stalls", n, 0);
    endtask

    task automatic t_hold();
        int n;
        drain();
        issue(C_ALUI, 5'd1, 5'd7, 5'd0, 1'b0, n);
        issue(C_ALU, 5'd7, 5'd1, 5'd9, 1'b1, n);
        chk("R7 stall observed", n, 3);
        filler();
        chk("R7 held instruction enters execute", ex_dst, 9);
        chk("R7 held instruction valid", ex_valid, 1);
    endtask

    task automatic t_dual_match();
        int n, n1;
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd5, 1'b0, n);
        issue(C_ALU, 5'd1, 5'd2, 5'd6, 1'b0, n);
        issue(C_ALU, 5'd5, 5'd6, 5'd8, 1'b0, n);
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd6, 1'b0, n1);
        issue(C_ALU, 5'd6, 5'd3, 5'd8, 1'b0, n1);
        chk("R2 R3 two sources, nearer producer rules", n, n1);
        chk("R3 dual match length", n, 3);
    endtask

    task automatic t_flow();
        int n, tot;
        drain();
        tot = 0;
        issue(C_ALU, 5'd1, 5'd2, 5'd3, 1'b0, n); tot += n;
        issue(C_ALU, 5'd1, 5'd2, 5'd4, 1'b0, n); tot += n;
        issue(C_LW,  5'd2, 5'd5, 5'd0, 1'b0, n); tot += n;
        issue(C_J,   5'd0, 5'd0, 5'd0, 1'b0, n); tot += n;
        chk("R10 no stall on independent stream", tot, 0);
        chk("R10 ex dst", ex_dst, 5);
        chk("R10 mem dst", mem_dst, 4);
        chk("R10 wb dst", wb_dst, 3);
        chk("R10 write enables", {ex_we, mem_we, wb_we}, 7);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        for (int k = 0; k < 4; k++) t_distance(k);
        t_second_src();
        t_read_enables();
        t_destinations();
        t_link_hazard();
        t_zero_reg();
        t_hold();
        t_dual_match();
        t_flow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule